// File: doc/BRIEF.md
# Register-Mapped SPI Master with Byte FIFOs

This block is an SPI bus master for a processor subsystem. Software reaches it through a 32-bit register port decoded on byte offsets. Bytes written to the transmit data register are queued in a transmit FIFO. Each queued byte is shifted out in SPI mode 0, most significant bit first. The byte sampled back at the same time is stored in a receive FIFO, where software reads it.

A control bit holds off transfers, so several bytes can be queued before the bus starts. The same control register has two write-only bits that empty either FIFO. Writing a fixed key to a reset register returns the whole block to its power-up state. Any other value written there is ignored.

Slave-select outputs follow a software register. The block raises one-cycle event strobes for a separate interrupt unit. A strobe marks each completed byte. Others mark the receive FIFO filling up and a received byte lost to a full receive FIFO.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the status register reads 0x5 and the control register reads 0. Both occupancy registers read 0 and every slave-select output is high. Status fields are: bit 0 receive empty, bit 1 receive full, bit 2 transmit empty, bit 3 transmit full. Register byte offsets are: key reset 0x40, control 0x60, status 0x64, transmit data 0x68, receive data 0x6C, slave select 0x70, transmit occupancy 0x74, receive occupancy 0x78.
- R2: Each byte is exchanged in SPI mode 0, most significant bit first. SCLK idles low and runs at the system clock divided by CLK_DIV. The sampled byte is pushed into the receive FIFO.
- R3: While control bit 8 is set, a write to transmit data only queues the byte and SCLK stays still. Clearing bit 8 drains every queued byte, in order.
- R4: Writing control with bit 5 set empties the transmit FIFO. Writing control with bit 6 set empties the receive FIFO. Neither bit is stored, so both read back as 0.
- R5: If a byte completes while the receive FIFO is full, the byte is dropped and evt_rx_overrun_o pulses. Otherwise the byte is pushed, and evt_rx_full_o pulses when that push fills the FIFO. Status bit 1 then reads 1.
- R6: A read of receive data while the receive FIFO is empty returns 0xDEADBEEF and changes no state.
- R7: Writing 0x0000000A to the key reset register restores the reset state of R1. Any other value written there has no effect.
- R8: A write to transmit data while the transmit FIFO is full is dropped, and status bit 3 reads 1.
- R9: The slave-select register resets to all ones. Output i is low exactly while register bit i is 0.
- R10: Writes to the status register change nothing.
- R11: Every completed byte pulses evt_tx_empty_o and evt_rx_not_empty_o for one cycle, including a byte that is dropped.
- R12: The occupancy registers read the current entry count of each FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe; pops the receive FIFO at the receive data offset |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the read |
| sclk_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |
| ss_no | output | NUM_SS | Active-low slave selects |
| evt_tx_empty_o | output | 1 | Byte-completed strobe |
| evt_rx_not_empty_o | output | 1 | Byte-received strobe |
| evt_rx_full_o | output | 1 | Receive FIFO became full |
| evt_rx_overrun_o | output | 1 | Received byte dropped |

## Verification
Two functions can fall in the same cycle: a byte completing on the bus, and software popping the receive data register while the receive FIFO is full. The bench fills the receive FIFO and queues one more byte. It then issues the read in exactly the cycle where the completion strobe is high. The full test is taken before the pop, so the bench expects the following results. The byte is dropped with an overrun pulse and no receive-full pulse. The read returns the oldest byte, and the receive occupancy ends one below the depth.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam logic [7:0] OFS_KEYRST = 8'h40;
  localparam logic [7:0] OFS_CTRL   = 8'h60;
  localparam logic [7:0] OFS_STAT   = 8'h64;
  localparam logic [7:0] OFS_TXD    = 8'h68;
  localparam logic [7:0] OFS_RXD    = 8'h6C;
  localparam logic [7:0] OFS_SSEL   = 8'h70;
  localparam logic [7:0] OFS_TXOCC  = 8'h74;
  localparam logic [7:0] OFS_RXOCC  = 8'h78;

  localparam logic [31:0] RESET_KEY   = 32'h0000_000A;
  localparam logic [31:0] RX_SENTINEL = 32'hDEAD_BEEF;

  localparam int CTRL_TXFLUSH = 5;
  localparam int CTRL_RXFLUSH = 6;
  localparam int CTRL_INHIBIT = 8;
endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic [AW:0]  count_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= wdata_i;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int CLK_DIV = 4,
  parameter int W       = 8,
  localparam int HALF   = CLK_DIV / 2,
  localparam int DW     = $clog2(HALF) + 1,
  localparam int BW     = $clog2(W) + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         start_i,
  input  logic [W-1:0] tx_byte_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] rx_byte_o,
  output logic         sclk_o,
  output logic         mosi_o,
  input  logic         miso_i
);
  logic         busy_q, done_q, sclk_q;
  logic [DW-1:0] div_q;
  logic [BW-1:0] bit_q;
  logic [W-1:0]  tx_q, rx_q;

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_byte_o = rx_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = tx_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_q <= 1'b0; sclk_q <= 1'b0;
      div_q  <= '0;   bit_q  <= '0;
      tx_q   <= '0;   rx_q   <= '0;
    end else if (clear_i) begin
      busy_q <= 1'b0; done_q <= 1'b0; sclk_q <= 1'b0;
      div_q  <= '0;   bit_q  <= '0;
      tx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          tx_q   <= tx_byte_i;
          bit_q  <= '0;
          div_q  <= '0;
          sclk_q <= 1'b0;
        end
      end else if (div_q == DW'(HALF-1)) begin
        div_q <= '0;
        if (!sclk_q) begin
          // leading edge: sample
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[W-2:0], miso_i};
        end else begin
          // trailing edge: shift or finish
          sclk_q <= 1'b0;
          if (bit_q == BW'(W-1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[W-2:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int FIFO_DEPTH = 256,
  parameter int NUM_SS     = 2,
  parameter int CLK_DIV    = 4,
  localparam int AW        = $clog2(FIFO_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SS-1:0] ss_no,
  output logic              evt_tx_empty_o,
  output logic              evt_rx_not_empty_o,
  output logic              evt_rx_full_o,
  output logic              evt_rx_overrun_o
);
  logic [31:0]       ctrl_q;
  logic [NUM_SS-1:0] ss_q;
  logic              ctrl_inhibit_q;
  logic              soft_rst, wr_ctrl, tx_flush, rx_flush;
  logic              tx_push, tx_pop, tx_empty, tx_full;
  logic              rx_push, rx_pop, rx_empty, rx_full;
  logic [7:0]        tx_head, rx_head, eng_rx;
  logic [AW:0]       tx_count, rx_count;
  logic              eng_busy, eng_done;

  assign soft_rst = reg_we_i && reg_addr_i == OFS_KEYRST && reg_wdata_i == RESET_KEY;
  assign wr_ctrl  = reg_we_i && reg_addr_i == OFS_CTRL;
  assign tx_flush = soft_rst || (wr_ctrl && reg_wdata_i[CTRL_TXFLUSH]);
  assign rx_flush = soft_rst || (wr_ctrl && reg_wdata_i[CTRL_RXFLUSH]);
  assign ctrl_inhibit_q = ctrl_q[CTRL_INHIBIT];

  assign tx_push = reg_we_i && reg_addr_i == OFS_TXD && !tx_full;
  assign tx_pop  = !ctrl_inhibit_q && !eng_busy && !tx_empty && !tx_flush;
  assign rx_pop  = reg_re_i && reg_addr_i == OFS_RXD && !rx_empty;
  // full is judged before any pop in the same cycle
  assign rx_push = eng_done && !rx_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ss_q   <= '1;
    end else if (soft_rst) begin
      ctrl_q <= '0;
      ss_q   <= '1;
    end else begin
      if (wr_ctrl)
        ctrl_q <= reg_wdata_i & ~((32'd1 << CTRL_TXFLUSH) | (32'd1 << CTRL_RXFLUSH));
      if (reg_we_i && reg_addr_i == OFS_SSEL)
        ss_q <= reg_wdata_i[NUM_SS-1:0];
    end
  end

  spi_fifo_buf #(.DEPTH(FIFO_DEPTH), .W(8)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(tx_flush), .push_i(tx_push), .wdata_i(reg_wdata_i[7:0]),
    .pop_i(tx_pop), .rdata_o(tx_head), .count_o(tx_count),
    .empty_o(tx_empty), .full_o(tx_full));

  spi_fifo_buf #(.DEPTH(FIFO_DEPTH), .W(8)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(rx_flush), .push_i(rx_push), .wdata_i(eng_rx),
    .pop_i(rx_pop), .rdata_o(rx_head), .count_o(rx_count),
    .empty_o(rx_empty), .full_o(rx_full));

  spi_shift_engine #(.CLK_DIV(CLK_DIV), .W(8)) u_engine (
    .clk_i, .rst_ni, .clear_i(soft_rst), .start_i(tx_pop), .tx_byte_i(tx_head),
    .busy_o(eng_busy), .done_o(eng_done), .rx_byte_o(eng_rx),
    .sclk_o, .mosi_o, .miso_i);

  for (genvar i = 0; i < NUM_SS; i++) begin : g_ss
    assign ss_no[i] = ss_q[i];
  end

  assign evt_tx_empty_o     = eng_done;
  assign evt_rx_not_empty_o = eng_done;
  assign evt_rx_overrun_o   = eng_done && rx_full;
  assign evt_rx_full_o      = rx_push && !rx_pop && rx_count == (AW+1)'(FIFO_DEPTH-1);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_CTRL:  reg_rdata_o = ctrl_q;
      OFS_STAT:  reg_rdata_o = {28'd0, tx_full, tx_empty, rx_full, rx_empty};
      OFS_RXD:   reg_rdata_o = rx_empty ? RX_SENTINEL : {24'd0, rx_head};
      OFS_SSEL:  reg_rdata_o = 32'(ss_q);
      OFS_TXOCC: reg_rdata_o = 32'(tx_count);
      OFS_RXOCC: reg_rdata_o = 32'(rx_count);
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int FIFO_DEPTH = 256,
  parameter int NUM_SS     = 2,
  localparam int AW        = $clog2(FIFO_DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic [7:0]        reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic [31:0]       reg_rdata_o,
  input logic              sclk_o,
  input logic [NUM_SS-1:0] ss_no,
  input logic              evt_rx_overrun_o,
  input logic [AW:0]       rx_count,
  input logic [AW:0]       tx_count,
  input logic              inhibit,
  input logic              busy
);
  a_r7_key_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 8'h40 && reg_wdata_i == 32'hA) |=> ((&ss_no) && tx_count == '0 && rx_count == '0));

  a_r6_sentinel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i == 8'h6C && rx_count == '0) |-> reg_rdata_o == 32'hDEADBEEF);

  a_r5_overrun_only_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_rx_overrun_o |-> rx_count == (AW+1)'(FIFO_DEPTH));

  a_r3_inhibit_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit && !busy) |=> !busy);

  a_r2_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !sclk_o);

  a_r8_tx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_count == (AW+1)'(FIFO_DEPTH) && reg_we_i && reg_addr_i == 8'h68) |=> tx_count <= (AW+1)'(FIFO_DEPTH));
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.FIFO_DEPTH(FIFO_DEPTH), .NUM_SS(NUM_SS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_re_i(reg_re_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .sclk_o(sclk_o), .ss_no(ss_no), .evt_rx_overrun_o(evt_rx_overrun_o),
  .rx_count(rx_count), .tx_count(tx_count), .inhibit(ctrl_inhibit_q), .busy(eng_busy));

// File: tb/spi_fifo_master_bench.sv
module spi_fifo_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int NSS        = 2;
  localparam int DIV        = 4;
  localparam logic [7:0] A_KEY = 8'h40, A_CTRL = 8'h60, A_STAT = 8'h64, A_TXD = 8'h68,
                         A_RXD = 8'h6C, A_SS = 8'h70, A_TXO = 8'h74, A_RXO = 8'h78;

  logic clk = 0, rst_n = 0;
  logic we = 0, re = 0, miso;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic sclk, mosi;
  logic [NSS-1:0] ss_n;
  logic e_txe, e_rxne, e_rxf, e_ovr;
  logic loop_mode = 1;
  logic [7:0] slv_q = 8'hC5;
  int tests = 0, fails = 0;
  int n_txe = 0, n_rxne = 0, n_rxf = 0, n_ovr = 0, n_rise = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_master #(.FIFO_DEPTH(DEPTH), .NUM_SS(NSS), .CLK_DIV(DIV)) u_spi_fifo_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso),
    .ss_no(ss_n), .evt_tx_empty_o(e_txe), .evt_rx_not_empty_o(e_rxne),
    .evt_rx_full_o(e_rxf), .evt_rx_overrun_o(e_ovr));

  // slave model: rotates a fixed byte, one bit per trailing edge
  assign miso = loop_mode ? mosi : slv_q[7];
  always @(negedge sclk) slv_q <= {slv_q[6:0], slv_q[7]};
  always @(posedge sclk) n_rise++;
  always @(negedge clk) begin
    if (e_txe)  n_txe++;
    if (e_rxne) n_rxne++;
    if (e_rxf)  n_rxf++;
    if (e_ovr)  n_ovr++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); re = 1; addr = a; #1 d = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic wait_bytes(input int n);
    repeat (n * (DIV*8 + 2) + 8) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_STAT, d); check("R1 status", d, 32'h5);
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    rd(A_TXO, d);  check("R1 txocc", d, 0);
    rd(A_RXO, d);  check("R1 rxocc", d, 0);
    check("R1/R9 ss", 32'(ss_n), 32'h3);
  endtask

  task automatic t_loopback;
    logic [31:0] d;
    int t0 = n_txe, r0 = n_rxne;
    loop_mode = 1;
    wr(A_TXD, 32'hA5); wr(A_TXD, 32'h3C);
    wait_bytes(2);
    rd(A_RXO, d); check("R12 rxocc", d, 2);
    rd(A_RXD, d); check("R2 loop byte0", d, 32'hA5);
    rd(A_RXD, d); check("R2 loop byte1", d, 32'h3C);
    check("R11 tx_empty strobes", n_txe - t0, 2);
    check("R11 rx_not_empty strobes", n_rxne - r0, 2);
    loop_mode = 0;
    wr(A_TXD, 32'h12); wait_bytes(1);
    rd(A_RXD, d); check("R2 slave byte msb first", d, 32'hC5);
    loop_mode = 1;
  endtask

  task automatic t_sclk;
    time ta, tb;
    logic [31:0] d;
    wr(A_TXD, 32'h00);
    @(posedge sclk); ta = $time;
    @(posedge sclk); tb = $time;
    check("R2 sclk period", 32'(tb - ta), 32'(DIV*CLK_PERIOD));
    wait_bytes(1);
    check("R2 sclk idle low", 32'(sclk), 0);
    rd(A_RXD, d);
  endtask

  task automatic t_inhibit;
    logic [31:0] d;
    int r0;
    wr(A_CTRL, 32'h100);
    r0 = n_rise;
    wr(A_TXD, 1); wr(A_TXD, 2); wr(A_TXD, 3);
    repeat (60) @(negedge clk);
    check("R3 no sclk while inhibited", n_rise - r0, 0);
    rd(A_TXO, d); check("R3/R12 txocc queued", d, 3);
    wr(A_CTRL, 0);
    wait_bytes(3);
    rd(A_TXO, d); check("R3 drained", d, 0);
    for (int i = 1; i <= 3; i++) begin
      rd(A_RXD, d); check("R3 order", d, 32'(i));
    end
  endtask

  task automatic t_flush;
    logic [31:0] d;
    wr(A_TXD, 7); wr(A_TXD, 8); wait_bytes(2);
    wr(A_CTRL, 32'h40);
    rd(A_RXO, d); check("R4 rx flushed", d, 0);
    rd(A_STAT, d); check("R4 status after rx flush", d, 32'h5);
    wr(A_CTRL, 32'h100); wr(A_TXD, 9); wr(A_TXD, 10);
    wr(A_CTRL, 32'h120);
    rd(A_TXO, d); check("R4 tx flushed", d, 0);
    rd(A_CTRL, d); check("R4 flush bits not stored", d, 32'h100);
    wr(A_CTRL, 0); wait_bytes(1);
    rd(A_RXO, d); check("R4 nothing sent after flush", d, 0);
  endtask

  task automatic t_txfull;
    logic [31:0] d;
    wr(A_CTRL, 32'h100);
    for (int i = 0; i <= DEPTH; i++) wr(A_TXD, 32'(i));
    rd(A_TXO, d); check("R8 txocc capped", d, DEPTH);
    rd(A_STAT, d); check("R8 status tx full", d, 32'h9);
    wr(A_STAT, 32'hF);
    rd(A_STAT, d); check("R10 status write ignored", d, 32'h9);
    wr(A_CTRL, 32'h120); wr(A_CTRL, 0);
  endtask

  task automatic t_ss;
    wr(A_SS, 32'h2);
    check("R9 ss bit0 low", 32'(ss_n), 32'h2);
    wr(A_SS, 32'h1);
    check("R9 ss bit1 low", 32'(ss_n), 32'h1);
  endtask

  task automatic t_soft_reset;
    logic [31:0] d;
    wr(A_SS, 0); wr(A_CTRL, 32'h100); wr(A_TXD, 5);
    wr(A_KEY, 32'h5);
    check("R7 wrong key ss kept", 32'(ss_n), 0);
    rd(A_TXO, d); check("R7 wrong key txocc kept", d, 1);
    wr(A_KEY, 32'hA);
    check("R7 key ss ones", 32'(ss_n), 32'h3);
    rd(A_STAT, d); check("R7 key status", d, 32'h5);
    rd(A_CTRL, d); check("R7 key ctrl", d, 0);
  endtask

  task automatic t_overrun;
    logic [31:0] d;
    int f0, o0;
    wr(A_CTRL, 32'h100);
    for (int i = 0; i < DEPTH; i++) wr(A_TXD, 32'(8'h40 + i));
    f0 = n_rxf; o0 = n_ovr;
    wr(A_CTRL, 0); wait_bytes(DEPTH);
    check("R5 rx_full event once", n_rxf - f0, 1);
    rd(A_STAT, d); check("R5 status rx full", d, 32'h6);
    wr(A_TXD, 32'h77); wr(A_TXD, 32'h78); wait_bytes(2);
    check("R5 overrun events", n_ovr - o0, 2);
    rd(A_RXO, d); check("R5 rxocc stays full", d, DEPTH);
    // completion coinciding with a pop of a full FIFO
    o0 = n_ovr; f0 = n_rxf;
    wr(A_TXD, 32'h99);
    do @(negedge clk); while (!e_txe);
    re = 1; addr = A_RXD; #1 d = rdata;
    @(negedge clk); re = 0;
    check("R5 same-cycle read data", d, 32'h40);
    check("R5 same-cycle overrun", n_ovr - o0, 1);
    check("R5 same-cycle no full event", n_rxf - f0, 0);
    rd(A_RXO, d); check("R5 same-cycle rxocc", d, DEPTH - 1);
    rd(A_RXD, d); check("R5 next byte", d, 32'h41);
  endtask

  task automatic t_sentinel;
    logic [31:0] d;
    wr(A_CTRL, 32'h40);
    rd(A_RXD, d); check("R6 sentinel", d, 32'hDEADBEEF);
    rd(A_RXO, d); check("R6 rxocc unchanged", d, 0);
    rd(A_STAT, d); check("R6 status unchanged", d, 32'h5);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_loopback();
    t_sclk();
    t_inhibit();
    t_flush();
    t_txfull();
    t_ss();
    t_soft_reset();
    t_overrun();
    t_sentinel();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule